// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple request port and an array of asynchronous fast-page-mode DRAM devices that forms a 64-bit word from 16-bit parts. The row and the column share one multiplexed address bus. The row is taken by the array when the row strobe goes low, and the column is taken when a column strobe goes low. There is one active-low column strobe for each byte lane, so a byte mask on the request becomes the set of lanes whose strobe falls.

After an access the controller keeps the row open. A later request to the same row then needs only a column cycle. A request to another row closes the page: the row strobe rises, the precharge time is met, and the new row is opened. The page is also closed when the time the row strobe has spent low nears its budget. Writes are always early writes. The write enable falls, and the write data is driven, one cycle before any column strobe falls, so the array never drives the data bus during a write.

A separate refresh sequencer asks for the bus through a request/grant pair. It gets the grant only once the page is closed and precharge has finished. Every DRAM timing limit is a parameter counted in clock cycles. Each one is rounded up from the nanosecond figure of the speed grade in use.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the row strobe, all eight column strobes, the write enable and the output enable are high, the data-out enable is low, and no grant and no response are given.
- R2: The row strobe falls only after it has been high for at least T_RP cycles, and this applies after reset too. The row address (the upper ROW_W bits of req_addr) is on dram_addr when the row strobe falls.
- R3: When a closed page is opened, the column strobes fall exactly T_RCD+1 cycles after the row strobe falls. The column address (the lower COL_W bits of req_addr) is on dram_addr when they fall. A column strobe is never low while the row strobe is high.
- R4: For a write, dram_we_n is low and dram_dq_oe is high at least one cycle before any column strobe falls. dram_oe_n stays high for the whole write. dram_dq_oe is high only while dram_we_n is low.
- R5: Column strobe bit i (byte lane i, data bits 8i+7..8i) falls only when req_be bit i was set. Lanes whose mask bit is clear are not written.
- R6: For a read, the data is captured after the column strobes have been low for T_CAS cycles and the row strobe has been low for T_RAC cycles. Lanes whose mask bit is clear read back as zero. rsp_valid is a single-cycle pulse.
- R7: A request to the open row, when the budget allows a full page cycle, runs with no row-strobe edge. The column strobes stay high for at least T_CP cycles between page cycles.
- R8: A request to a different row raises the row strobe, precharges, and opens the new row with exactly one new fall of the row strobe.
- R9: The row strobe never stays low for more than T_RASP_MAX cycles. An idle open page is closed by the controller on its own before that limit.
- R10: ref_gnt is raised only when the row strobe has been high for at least T_RP cycles. While it is high, every strobe is high and no request is accepted. After ref_req falls, the row strobe waits at least T_RP cycles before falling again.
- R11: Each low phase of the row strobe lasts at least T_RAS_MIN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte-lane mask, bit i for bits 8i+7..8i |
| req_ready | output | 1 | Request accepted in this cycle when req_valid is high |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DW | Read data, unmasked lanes zero |
| ref_req | input | 1 | Refresh sequencer asks for the bus |
| ref_gnt | output | 1 | Bus handed to the refresh sequencer |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | DW/8 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DW | Data driven to the array |
| dram_dq_oe | output | 1 | Enable for dram_dq_out |
| dram_dq_in | input | DW | Data returned by the array |

## Verification
The hardest state to reach from the ports is the page that closes on its own. The row strobe has to stay low long enough to use up its budget, and no miss or refresh may close it first. The bench builds the DUT with a short budget and opens a page with a few accesses. It then leaves the request port idle for longer than the budget and checks that the row strobe has risen. A read to the same row must then cost exactly one new row-strobe fall. A second hard case is the refresh handover from an open page. A request is held pending during the grant, and the bench measures the precharge gap from the release of ref_req to the next fall of the row strobe.

// File: rtl/fpm_pkg.sv
// Shared types for the fast page mode DRAM controller.
package fpm_pkg;
    // Sequencer states: idle with page open or closed, row open, column
    // setup, column strobe low, column precharge, bus lent to refresh.
    typedef enum logic [2:0] {
        S_IDLE, S_ROW, S_CSET, S_CAS, S_CPRE, S_REF
    } seq_state_t;
endpackage

// File: rtl/fpm_page_track.sv
// Row strobe owner. Holds the open row and counts cycles spent with the
// row strobe low or high. From these counts it reports precharge met,
// minimum low time met, access-from-row met and page budget left.
// Assumes open_i and close_i are never high together and T_RASP_MAX
// exceeds T_RAC + PAGE_CYC.
module fpm_page_track #(
    parameter int ROW_W      = 12,
    parameter int T_RP       = 8,
    parameter int T_RAS_MIN  = 13,
    parameter int T_RAC      = 13,
    parameter int T_RASP_MAX = 50000,
    parameter int PAGE_CYC   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic             ref_done_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             ras_n_o,
    output logic             row_hit_o,
    output logic             trp_met_o,
    output logic             tras_met_o,
    output logic             rac_met_o,
    output logic             budget_ok_o
);
    localparam int CW = $clog2(T_RASP_MAX + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(T_RASP_MAX);
    localparam logic [CW-1:0] TRP_LIM  = CW'(T_RP - 1);
    localparam logic [CW-1:0] TRAS_LIM = CW'(T_RAS_MIN - 1);
    localparam logic [CW-1:0] TRAC_LIM = CW'(T_RAC - 1);
    localparam logic [CW-1:0] BUD_LIM  = CW'(T_RASP_MAX - PAGE_CYC - 1);

    logic             ras_n_q;
    logic [CW-1:0]    low_cnt;
    logic [CW-1:0]    high_cnt;
    logic [ROW_W-1:0] open_row;

    // Row strobe level, open row and the saturating phase counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n_q  <= 1'b1;
            low_cnt  <= '0;
            high_cnt <= '0;
            open_row <= '0;
        end else if (open_i) begin
            ras_n_q  <= 1'b0;
            low_cnt  <= '0;
            open_row <= row_i;
        end else if (close_i) begin
            ras_n_q  <= 1'b1;
            high_cnt <= '0;
        end else if (ref_done_i) begin
            high_cnt <= '0;
        end else if (ras_n_q) begin
            if (high_cnt != CNT_MAX) high_cnt <= high_cnt + 1'b1;
        end else begin
            if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
        end
    end

    // Timing flags seen by the sequencer.
    always_comb begin
        ras_n_o     = ras_n_q;
        row_hit_o   = !ras_n_q && (open_row == row_i);
        trp_met_o   = ras_n_q && (high_cnt >= TRP_LIM);
        tras_met_o  = !ras_n_q && (low_cnt >= TRAS_LIM);
        rac_met_o   = !ras_n_q && (low_cnt >= TRAC_LIM);
        budget_ok_o = !ras_n_q && (low_cnt <= BUD_LIM);
    end

    // R2: row strobe falls only after the precharge count is met
    assert_precharge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_q) |-> ($past(high_cnt) >= TRP_LIM));
    // R11: row strobe rises only after the minimum low time
    assert_ras_min_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_q) |-> ($past(low_cnt) >= TRAS_LIM));
    // R9: low phase stays inside the budget
    assert_ras_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_q |-> (low_cnt < CNT_MAX));
endmodule

// File: rtl/fpm_byte_lanes.sv
// Per-byte column strobes and read-lane masking. A lane strobes only
// when its mask bit is set, and a lane that did not strobe returns zero.
module fpm_byte_lanes #(
    parameter int NB = 8
) (
    input  logic            cas_act_i,
    input  logic [NB-1:0]   be_i,
    input  logic [NB*8-1:0] dq_in_i,
    output logic [NB-1:0]   cas_n_o,
    output logic [NB*8-1:0] rd_o
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        // One lane: strobe and masked read byte.
        always_comb begin
            cas_n_o[i]      = !(cas_act_i && be_i[i]);
            rd_o[8*i +: 8]  = be_i[i] ? dq_in_i[8*i +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/fpm_seq.sv
// Access sequencer. It accepts requests, decides between hit, miss,
// close and refresh handover, and walks each column cycle through
// setup, strobe and precharge. Writes are early writes: the write
// enable and the data are set up one cycle before the strobes fall.
// Assumes the request fields stay stable while req_valid waits.
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 10,
    parameter int AW    = 12,
    parameter int DW    = 64,
    parameter int NB    = 8,
    parameter int T_RCD = 5,
    parameter int T_CAS = 5,
    parameter int T_CP  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DW-1:0]          req_wdata,
    input  logic [NB-1:0]          req_be,
    output logic                   req_ready,
    input  logic                   ref_req,
    output logic                   ref_gnt,
    input  logic                   page_open,
    input  logic                   row_hit,
    input  logic                   trp_met,
    input  logic                   tras_met,
    input  logic                   rac_met,
    input  logic                   budget_ok,
    output logic                   open_o,
    output logic                   close_o,
    output logic                   ref_done_o,
    output logic [AW-1:0]          addr_o,
    output logic                   cas_act_o,
    output logic [NB-1:0]          be_o,
    output logic                   we_n_o,
    output logic                   oe_n_o,
    output logic                   dq_oe_o,
    output logic [DW-1:0]          wdata_o,
    input  logic [DW-1:0]          rd_lane_i,
    output logic                   rsp_valid_o,
    output logic [DW-1:0]          rsp_rdata_o
);
    localparam int SEQ_CW = $clog2(T_RCD + T_CAS + T_CP + 2);
    localparam logic [SEQ_CW-1:0] CNT_SAT = '1;
    localparam logic [SEQ_CW-1:0] RCD_END = SEQ_CW'(T_RCD - 1);
    localparam logic [SEQ_CW-1:0] CAS_END = SEQ_CW'(T_CAS - 1);
    localparam logic [SEQ_CW-1:0] CP_END  = SEQ_CW'(T_CP - 1);

    seq_state_t        state, state_nx;
    logic [SEQ_CW-1:0] cnt;
    logic              write_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DW-1:0]     wdata_q;
    logic [NB-1:0]     be_q;
    logic              accept_hit, accept_new, go_ref, capture;
    logic              rsp_valid_q;
    logic [DW-1:0]     rsp_rdata_q;

    // Idle decisions: hit, new row, close, refresh handover.
    always_comb begin
        accept_hit = (state == S_IDLE) && req_valid && !ref_req &&
                     page_open && row_hit && budget_ok;
        accept_new = (state == S_IDLE) && req_valid && !ref_req &&
                     !page_open && trp_met;
        go_ref     = (state == S_IDLE) && ref_req && !page_open && trp_met;
        close_o    = (state == S_IDLE) && page_open && tras_met &&
                     (ref_req || !budget_ok || (req_valid && !row_hit));
        open_o     = accept_new;
        req_ready  = accept_hit || accept_new;
        ref_done_o = (state == S_REF) && !ref_req;
        capture    = (state == S_CAS) && (cnt >= CAS_END) && rac_met;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE: if (accept_new) state_nx = S_ROW;
                    else if (accept_hit) state_nx = S_CSET;
                    else if (go_ref) state_nx = S_REF;
            S_ROW:  if (cnt == RCD_END) state_nx = S_CSET;
            S_CSET: state_nx = S_CAS;
            S_CAS:  if (capture) state_nx = S_CPRE;
            S_CPRE: if (cnt == CP_END) state_nx = S_IDLE;
            S_REF:  if (!ref_req) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register and per-state cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) cnt <= '0;
            else if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
    end

    // Request latch on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (req_ready && req_valid) begin
            write_q <= req_write;
            row_q   <= req_addr[ROW_W+COL_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Read data capture and one-cycle response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= capture && !write_q;
            if (capture && !write_q) rsp_rdata_q <= rd_lane_i;
        end
    end

    // DRAM-side control decoded from state and latched request.
    always_comb begin
        addr_o    = (state == S_CSET || state == S_CAS || state == S_CPRE) ?
                    AW'(col_q) : AW'(row_q);
        cas_act_o = (state == S_CAS);
        be_o      = be_q;
        dq_oe_o   = write_q && (state == S_CSET || state == S_CAS);
        we_n_o    = !dq_oe_o;
        oe_n_o    = !((state == S_CAS) && !write_q);
        wdata_o   = wdata_q;
        ref_gnt   = (state == S_REF);
        rsp_valid_o = rsp_valid_q;
        rsp_rdata_o = rsp_rdata_q;
    end

    // R6: response is a single-cycle pulse
    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_q |=> !rsp_valid_q);
    // R10: no request is taken while the bus is lent out
    assert_no_accept_in_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REF) |-> !req_ready);
endmodule

// File: rtl/fpm_dram_ctrl.sv
// Top of the fast page mode DRAM controller. It ties the sequencer, the
// row strobe tracker and the per-byte lane logic to the request port
// and the DRAM pins. Timing parameters are clock cycles, rounded up
// from the nanosecond limits. Data in and out are split. The
// surrounding pad logic joins them using dram_dq_oe.
module fpm_dram_ctrl #(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 10,
    parameter int DW         = 64,
    parameter int T_RP       = 8,
    parameter int T_RAS_MIN  = 13,
    parameter int T_RCD      = 5,
    parameter int T_CAS      = 5,
    parameter int T_CP       = 3,
    parameter int T_RAC      = 13,
    parameter int T_RASP_MAX = 50000,
    parameter int NB         = DW / 8,
    parameter int AW         = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DW-1:0]          req_wdata,
    input  logic [NB-1:0]          req_be,
    output logic                   req_ready,
    output logic                   rsp_valid,
    output logic [DW-1:0]          rsp_rdata,
    input  logic                   ref_req,
    output logic                   ref_gnt,
    output logic [AW-1:0]          dram_addr,
    output logic                   dram_ras_n,
    output logic [NB-1:0]          dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DW-1:0]          dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DW-1:0]          dram_dq_in
);
    localparam int PAGE_CYC = 2 + T_CAS + T_CP;

    logic open_s, close_s, ref_done_s;
    logic row_hit_s, trp_met_s, tras_met_s, rac_met_s, budget_ok_s;
    logic cas_act_s;
    logic [NB-1:0] be_s;
    logic [DW-1:0] rd_lane_s;

    fpm_page_track #(
        .ROW_W(ROW_W), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RAC(T_RAC),
        .T_RASP_MAX(T_RASP_MAX), .PAGE_CYC(PAGE_CYC)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .open_i(open_s), .close_i(close_s),
        .ref_done_i(ref_done_s), .row_i(req_addr[ROW_W+COL_W-1:COL_W]),
        .ras_n_o(dram_ras_n), .row_hit_o(row_hit_s), .trp_met_o(trp_met_s),
        .tras_met_o(tras_met_s), .rac_met_o(rac_met_s), .budget_ok_o(budget_ok_s)
    );

    fpm_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .AW(AW), .DW(DW), .NB(NB),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .page_open(!dram_ras_n), .row_hit(row_hit_s), .trp_met(trp_met_s),
        .tras_met(tras_met_s), .rac_met(rac_met_s), .budget_ok(budget_ok_s),
        .open_o(open_s), .close_o(close_s), .ref_done_o(ref_done_s),
        .addr_o(dram_addr), .cas_act_o(cas_act_s), .be_o(be_s),
        .we_n_o(dram_we_n), .oe_n_o(dram_oe_n), .dq_oe_o(dram_dq_oe),
        .wdata_o(dram_dq_out), .rd_lane_i(rd_lane_s),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata)
    );

    fpm_byte_lanes #(.NB(NB)) u_lanes (
        .cas_act_i(cas_act_s), .be_i(be_s), .dq_in_i(dram_dq_in),
        .cas_n_o(dram_cas_n), .rd_o(rd_lane_s)
    );

    // R3: column strobes only inside a row-strobe low phase
    assert_cas_inside_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(&dram_cas_n) |-> !dram_ras_n);
    // R4: write enable already low in the cycle before strobes fall
    assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&dram_cas_n) && !(&dram_cas_n) && !dram_we_n) |-> !$past(dram_we_n));
    // R4: array outputs never enabled during a write
    assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);
    // R10: all strobes idle while refresh owns the bus
    assert_ref_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (dram_ras_n && (&dram_cas_n) && dram_we_n));
endmodule

// File: tb/fpm_dram_ctrl_bench.sv
// Directed bench with a behavioural array model and a pin-timing monitor.
module fpm_dram_ctrl_bench;
    localparam int ROW_W = 12, COL_W = 10, DW = 64, NB = 8, AW = 12;
    localparam int T_RP = 8, T_RAS_MIN = 13, T_RCD = 5, T_CAS = 5, T_CP = 3;
    localparam int T_RAC = 13, T_RASP_MAX = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                   req_valid = 1'b0, req_write = 1'b0;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic [DW-1:0]          req_wdata = '0;
    logic [NB-1:0]          req_be = '0;
    logic                   req_ready, rsp_valid, ref_gnt;
    logic [DW-1:0]          rsp_rdata;
    logic                   ref_req = 1'b0;
    logic [AW-1:0]          dram_addr;
    logic                   dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [NB-1:0]          dram_cas_n;
    logic [DW-1:0]          dram_dq_out;
    logic [DW-1:0]          dram_dq_in = '0;

    fpm_dram_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAC(T_RAC),
        .T_RASP_MAX(T_RASP_MAX)
    ) u_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Array model and pin monitor, sampled on the falling clock edge.
    logic [63:0] mem [int unsigned];
    logic [ROW_W-1:0] row_m = '0;
    logic [COL_W-1:0] exp_col = '0;
    logic [ROW_W-1:0] exp_row = '0;
    logic [NB-1:0] last_cas_pat = '1;
    bit prev_ras = 1, prev_casall = 1, prev_we = 1, first_cas = 0;
    int hi_len = 0, lo_len = 0, cas_hi_len = 0, fall_cyc = 0, nfalls = 0;

    always @(negedge clk) begin : mon
        int unsigned k;
        logic [63:0] w;
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                chk(hi_len >= T_RP, "R2 precharge before row strobe", 64'(hi_len), 64'(T_RP));
                chk(dram_addr == AW'(exp_row), "R2 row address", 64'(dram_addr), 64'(exp_row));
                row_m = dram_addr[ROW_W-1:0];
                fall_cyc = cyc; first_cas = 1; nfalls++;
            end
            if (!prev_ras && dram_ras_n) begin
                chk(lo_len >= T_RAS_MIN, "R11 row strobe low time", 64'(lo_len), 64'(T_RAS_MIN));
                chk(lo_len <= T_RASP_MAX, "R9 row strobe budget", 64'(lo_len), 64'(T_RASP_MAX));
            end
            k = {row_m, dram_addr[COL_W-1:0]};
            if (prev_casall && !(&dram_cas_n)) begin
                last_cas_pat = dram_cas_n;
                if (first_cas)
                    chk(cyc - fall_cyc == T_RCD + 1, "R3 row-to-column delay",
                        64'(cyc - fall_cyc), 64'(T_RCD + 1));
                else
                    chk(cas_hi_len >= T_CP, "R7 column precharge", 64'(cas_hi_len), 64'(T_CP));
                first_cas = 0;
                chk(dram_addr == AW'(exp_col), "R3 column address", 64'(dram_addr), 64'(exp_col));
                chk(!dram_ras_n, "R3 column strobe inside row strobe", 64'(dram_ras_n), 64'd0);
                if (!dram_we_n) begin
                    chk(!prev_we && dram_dq_oe, "R4 early write setup", 64'(prev_we), 64'd0);
                    w = mem.exists(k) ? mem[k] : 64'h0;
                    for (int i = 0; i < NB; i++)
                        if (!dram_cas_n[i]) w[8*i +: 8] = dram_dq_out[8*i +: 8];
                    mem[k] = w;
                end
            end
            if (!(&dram_cas_n)) dram_dq_in = mem.exists(k) ? mem[k] : 64'h0;
            if (!dram_we_n) chk(dram_oe_n, "R4 output enable off in write", 64'(dram_oe_n), 64'd1);
            if (dram_dq_oe) chk(!dram_we_n, "R4 data drive only in write", 64'(dram_we_n), 64'd0);
            if (ref_gnt) chk(dram_ras_n && (&dram_cas_n), "R10 strobes idle in grant",
                             64'(dram_ras_n), 64'd1);
        end
        hi_len     = dram_ras_n ? (prev_ras ? hi_len + 1 : 1) : 0;
        lo_len     = !dram_ras_n ? (!prev_ras ? lo_len + 1 : 1) : 0;
        cas_hi_len = (&dram_cas_n) ? (prev_casall ? cas_hi_len + 1 : 1) : 0;
        prev_ras = dram_ras_n; prev_casall = &dram_cas_n; prev_we = dram_we_n;
    end

    task automatic do_access(input bit wr, input logic [ROW_W-1:0] row,
                             input logic [COL_W-1:0] col, input logic [63:0] wd,
                             input logic [7:0] be, output logic [63:0] rd);
        rd = '0;
        exp_col = col; exp_row = row;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = {row, col}; req_wdata = wd; req_be = be;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 0;
        if (!wr) begin
            while (!rsp_valid) @(negedge clk);
            rd = rsp_rdata;
            @(negedge clk);
            chk(!rsp_valid, "R6 response is one pulse", 64'(rsp_valid), 64'd0);
        end else begin
            repeat (12) @(negedge clk);
        end
        chk(last_cas_pat == ~be, "R5 lane strobes follow mask", 64'(last_cas_pat), 64'(~be));
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (4) @(negedge clk);
        chk(dram_ras_n && (&dram_cas_n) && dram_we_n && dram_oe_n && !dram_dq_oe,
            "R1 strobes idle in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 64'h7ff);
        chk(!ref_gnt && !rsp_valid, "R1 no grant or response", {ref_gnt, rsp_valid}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk(dram_ras_n && (&dram_cas_n), "R1 idle after reset", 64'(dram_ras_n), 64'd1);
        req_valid = 1; req_write = 0; req_addr = '0; req_be = '1;
        #1;
        chk(!req_ready, "R2 precharge honoured after reset", 64'(req_ready), 64'd0);
        req_valid = 0;
        repeat (T_RP) @(negedge clk);
    endtask

    task automatic t_first_access();
        logic [63:0] rd;
        int n0 = nfalls;
        do_access(1, 12'h003, 10'h007, 64'h0123_4567_89ab_cdef, 8'hff, rd);
        chk(nfalls == n0 + 1, "R2 one row opening", 64'(nfalls), 64'(n0 + 1));
        do_access(0, 12'h003, 10'h007, 64'h0, 8'hff, rd);
        chk(rd == 64'h0123_4567_89ab_cdef, "R6 read back", rd, 64'h0123_4567_89ab_cdef);
    endtask

    task automatic t_page_hit();
        logic [63:0] rd;
        int n0 = nfalls;
        do_access(1, 12'h003, 10'h008, 64'hdead_beef_cafe_f00d, 8'hff, rd);
        do_access(0, 12'h003, 10'h008, 64'h0, 8'hff, rd);
        chk(rd == 64'hdead_beef_cafe_f00d, "R7 hit read data", rd, 64'hdead_beef_cafe_f00d);
        do_access(0, 12'h003, 10'h007, 64'h0, 8'hff, rd);
        chk(rd == 64'h0123_4567_89ab_cdef, "R7 hit other column", rd, 64'h0123_4567_89ab_cdef);
        chk(nfalls == n0, "R7 no row strobe edge on hits", 64'(nfalls), 64'(n0));
    endtask

    task automatic t_page_miss();
        logic [63:0] rd;
        int n0 = nfalls;
        do_access(0, 12'h009, 10'h007, 64'h0, 8'hff, rd);
        chk(nfalls == n0 + 1, "R8 miss reopens once", 64'(nfalls), 64'(n0 + 1));
        chk(rd == 64'h0, "R8 miss reads new row", rd, 64'h0);
    endtask

    task automatic t_byte_lanes();
        logic [63:0] rd;
        do_access(1, 12'h009, 10'h005, 64'h1111_1111_1111_1111, 8'hff, rd);
        do_access(1, 12'h009, 10'h005, 64'haabb_ccdd_eeff_0102, 8'h0f, rd);
        do_access(0, 12'h009, 10'h005, 64'h0, 8'hff, rd);
        chk(rd == 64'h1111_1111_eeff_0102, "R5 masked lanes kept", rd, 64'h1111_1111_eeff_0102);
        do_access(0, 12'h009, 10'h005, 64'h0, 8'hf0, rd);
        chk(rd == 64'h1111_1111_0000_0000, "R6 unread lanes zero", rd, 64'h1111_1111_0000_0000);
    endtask

    task automatic t_budget();
        logic [63:0] rd;
        int n0;
        repeat (T_RASP_MAX + 20) @(negedge clk);
        chk(dram_ras_n, "R9 idle page closed by budget", 64'(dram_ras_n), 64'd1);
        n0 = nfalls;
        do_access(0, 12'h009, 10'h005, 64'h0, 8'hff, rd);
        chk(nfalls == n0 + 1, "R9 reopen after budget close", 64'(nfalls), 64'(n0 + 1));
        chk(rd == 64'h1111_1111_eeff_0102, "R9 data after reopen", rd, 64'h1111_1111_eeff_0102);
    endtask

    task automatic t_refresh();
        logic [63:0] rd;
        int rel_cyc, guard = 0;
        @(negedge clk);
        ref_req = 1;
        while (!ref_gnt && guard < 200) begin @(negedge clk); guard++; end
        chk(ref_gnt, "R10 grant given", 64'(ref_gnt), 64'd1);
        chk(dram_ras_n && hi_len >= T_RP, "R10 grant after precharge", 64'(hi_len), 64'(T_RP));
        req_valid = 1; req_write = 0; req_addr = {12'h009, 10'h005}; req_be = '1;
        for (int i = 0; i < 10; i++) begin
            #1;
            chk(!req_ready && dram_ras_n, "R10 request held off in grant", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        req_valid = 0;
        ref_req = 0;
        rel_cyc = cyc;
        do_access(0, 12'h009, 10'h005, 64'h0, 8'hff, rd);
        chk(fall_cyc - rel_cyc >= T_RP, "R10 precharge after release",
            64'(fall_cyc - rel_cyc), 64'(T_RP));
        chk(rd == 64'h1111_1111_eeff_0102, "R10 access after refresh", rd, 64'h1111_1111_eeff_0102);
    endtask

    initial begin : main
        t_reset();
        t_first_access();
        t_page_hit();
        t_page_miss();
        t_byte_lanes();
        t_budget();
        t_refresh();
        repeat (5) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run hung actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule